// File: doc/BRIEF.md
# Parallel NOR Flash Command Interpreter

This block models a parallel NOR flash device that is driven through a written command protocol. A host on a simple synchronous bus writes command bytes and data words, and the block interprets them across several bus cycles. It tracks the current step in a sequence (a phase counter) together with the latched command. Depending on that state, a write programs a word, erases a whole sector, loads a buffered-write count, confirms a sequence or changes what reads return.

The flash cells are stood in for by a small on-chip byte array. A program operation can only clear bits, as real cells do: the stored byte becomes the old byte AND the written byte. An erase sets every byte of the addressed sector back to 0xFF. No operation takes time; each one completes in the cycle its final write is accepted.

Reads return one of three things, chosen by the latched command: array data, the status byte, or a byte from a computed identification table. The identification table holds the "QRY" signature and the device geometry. Read data is registered, so it appears one clock after the read strobe.

Top module: `nor_cmd_flash`

## Requirements
- R1: After reset, the device is in read-array mode, the status byte is 0x00, every array byte reads 0xFF, and the phase counter is only nonzero while a command other than 0x00 is latched.
- R2: A first-cycle write of 0x10 or 0x40 arms a program. The next write stores old AND new data at its address, sets status bit 7 and returns to read-array mode.
- R3: A first-cycle write of 0x20 immediately fills the sector containing the address with 0xFF and sets status bit 7. On the second cycle, 0xD0 goes back to the first phase with status reads still selected. 0xFF, or any other value, returns to read-array mode.
- R4: A first-cycle write of 0x70 latches status-read mode and leaves the phase at the first cycle. While the latched command is 0x20, 0x60, 0x70 or 0xE8, reads return the status byte in bits 7:0 with all upper bits zero.
- R5: A first-cycle write of 0x50 clears the status byte to 0x00 and returns to read-array mode.
- R6: A first-cycle write of 0xE8 sets status bit 7. The next write's low byte gives a count N. The following N+1 writes each program a word at their own address. A following 0xD0 goes back to the first phase with status reads selected; any other value returns to read-array mode.
- R7: After a first-cycle 0x60, a second write of 0xD0 or 0x01 sets status bit 7 and keeps status reads selected. Any other value returns to read-array mode without touching the status byte.
- R8: In query mode (0x98), a read returns the table byte at index (address[7:0] >> log2(DATA_W/8)), zero-extended. Indices of 0x52 and above read 0. A write of 0xFF leaves query mode; any other write keeps it.
- R9: Table indices 0x10, 0x11 and 0x12 hold 0x51, 0x52 and 0x59 ("QRY"). Index 0x2A holds the buffer size code: 8 for an 8-bit device and 11 for a 16-bit one.
- R10: A first-cycle write of 0x00, 0xFF or any unrecognised code clears the latched command and the phase, so reads return array data.
- R11: The bus is byte-addressed and multi-byte words are little-endian. The byte at the address sits in bits 7:0 and the byte at address+1 in bits 15:8, both when reading and when programming.
- R12: Read data is registered. It changes only on a clock edge where the read strobe is high and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Byte address (at least 8 bits) |
| bus_wdata | input | DATA_W | Write data; command codes in bits 7:0 |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | DATA_W | Registered read data |

## Verification
The bench builds the block 16 bits wide, with four sectors of 16 bytes. The 16-bit width makes byte order observable: an odd-address read straddles two programmed words, and the query index is shifted by one. The 8-bit address space then reaches indices beyond the 0x52-entry table. The small sectors let one erase be checked against its neighbours, and the buffered write is run both with a correct confirm and with a wrong one.

// File: rtl/nfl_pkg.sv
package nfl_pkg;

    localparam logic [7:0] OP_NULL    = 8'h00;
    localparam logic [7:0] OP_LOCKSET = 8'h01;
    localparam logic [7:0] OP_PROG_A  = 8'h10;
    localparam logic [7:0] OP_ERASE   = 8'h20;
    localparam logic [7:0] OP_PROG_B  = 8'h40;
    localparam logic [7:0] OP_CLR     = 8'h50;
    localparam logic [7:0] OP_LOCK    = 8'h60;
    localparam logic [7:0] OP_STAT    = 8'h70;
    localparam logic [7:0] OP_QUERY   = 8'h98;
    localparam logic [7:0] OP_CONF    = 8'hD0;
    localparam logic [7:0] OP_BUF     = 8'hE8;
    localparam logic [7:0] OP_ARRAY   = 8'hFF;

    localparam logic [7:0] ST_READY   = 8'h80;
    localparam int         QRY_LEN    = 8'h52;

    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_ARG     = 2'd1,
        PH_DATA    = 2'd2,
        PH_CONFIRM = 2'd3
    } phase_t;

    typedef struct packed {
        logic [7:0] cmd;
        phase_t     ph;
        logic [7:0] stat;
        logic [7:0] cnt;
    } ctl_t;

endpackage

// File: rtl/nfl_ctl.sv
module nfl_ctl
    import nfl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we_i,
    input  logic [7:0] code_i,
    output logic [7:0] cmd_o,
    output phase_t     ph_o,
    output logic [7:0] stat_o,
    output logic [7:0] cnt_o,
    output logic       prog_o,
    output logic       erase_o
);

    ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d   = ctl_q;
        prog_o  = 1'b0;
        erase_o = 1'b0;
        if (we_i) begin
            unique case (ctl_q.ph)
                PH_IDLE: begin
                    case (code_i)
                        OP_PROG_A, OP_PROG_B, OP_LOCK, OP_QUERY: begin
                            ctl_d.cmd = code_i;
                            ctl_d.ph  = PH_ARG;
                        end
                        OP_ERASE: begin
                            erase_o    = 1'b1;
                            ctl_d.stat = ctl_q.stat | ST_READY;
                            ctl_d.cmd  = code_i;
                            ctl_d.ph   = PH_ARG;
                        end
                        OP_CLR: begin
                            ctl_d.stat = 8'h00;
                            ctl_d.cmd  = OP_NULL;
                            ctl_d.ph   = PH_IDLE;
                        end
                        OP_STAT: begin
                            ctl_d.cmd = code_i;
                        end
                        OP_BUF: begin
                            ctl_d.stat = ctl_q.stat | ST_READY;
                            ctl_d.cmd  = code_i;
                            ctl_d.ph   = PH_ARG;
                        end
                        default: begin
                            ctl_d.cmd = OP_NULL;
                            ctl_d.ph  = PH_IDLE;
                        end
                    endcase
                end
                PH_ARG: begin
                    case (ctl_q.cmd)
                        OP_PROG_A, OP_PROG_B: begin
                            prog_o     = 1'b1;
                            ctl_d.stat = ctl_q.stat | ST_READY;
                            ctl_d.cmd  = OP_NULL;
                            ctl_d.ph   = PH_IDLE;
                        end
                        OP_ERASE: begin
                            ctl_d.ph = PH_IDLE;
                            if (code_i != OP_CONF) ctl_d.cmd = OP_NULL;
                        end
                        OP_LOCK: begin
                            ctl_d.ph = PH_IDLE;
                            if (code_i == OP_CONF || code_i == OP_LOCKSET)
                                ctl_d.stat = ctl_q.stat | ST_READY;
                            else
                                ctl_d.cmd = OP_NULL;
                        end
                        OP_QUERY: begin
                            if (code_i == OP_ARRAY) begin
                                ctl_d.cmd = OP_NULL;
                                ctl_d.ph  = PH_IDLE;
                            end
                        end
                        OP_BUF: begin
                            ctl_d.cnt = code_i;
                            ctl_d.ph  = PH_DATA;
                        end
                        default: begin
                            ctl_d.cmd = OP_NULL;
                            ctl_d.ph  = PH_IDLE;
                        end
                    endcase
                end
                PH_DATA: begin
                    if (ctl_q.cmd == OP_BUF) begin
                        prog_o     = 1'b1;
                        ctl_d.stat = ctl_q.stat | ST_READY;
                        ctl_d.cnt  = ctl_q.cnt - 8'd1;
                        if (ctl_q.cnt == 8'd0) ctl_d.ph = PH_CONFIRM;
                    end else begin
                        ctl_d.cmd = OP_NULL;
                        ctl_d.ph  = PH_IDLE;
                    end
                end
                PH_CONFIRM: begin
                    ctl_d.ph = PH_IDLE;
                    if (ctl_q.cmd == OP_BUF && code_i == OP_CONF)
                        ctl_d.stat = ctl_q.stat | ST_READY;
                    else
                        ctl_d.cmd = OP_NULL;
                end
                default: begin
                    ctl_d.cmd = OP_NULL;
                    ctl_d.ph  = PH_IDLE;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q.cmd  <= OP_NULL;
            ctl_q.ph   <= PH_IDLE;
            ctl_q.stat <= 8'h00;
            ctl_q.cnt  <= 8'h00;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign cmd_o  = ctl_q.cmd;
    assign ph_o   = ctl_q.ph;
    assign stat_o = ctl_q.stat;
    assign cnt_o  = ctl_q.cnt;

endmodule

// File: rtl/nfl_cells.sv
module nfl_cells #(
    parameter int DATA_W     = 16,
    parameter int SECT_BYTES = 16,
    parameter int SECT_CNT   = 4,
    parameter int ADDR_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              prog_i,
    input  logic              erase_i,
    output logic [DATA_W-1:0] rword_o
);

    localparam int TOTAL = SECT_BYTES * SECT_CNT;
    localparam int AB    = $clog2(TOTAL);
    localparam int LANES = DATA_W / 8;

    logic [7:0]    mem_d [TOTAL];
    logic [7:0]    mem_q [TOTAL];
    logic [AB-1:0] base;
    logic [AB-1:0] lane_idx [LANES];
    int            sect_sel;

    assign base     = addr_i[AB-1:0];
    assign sect_sel = int'(base) / SECT_BYTES;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign lane_idx[k]        = base + AB'(k);
        assign rword_o[8*k +: 8]  = mem_q[lane_idx[k]];
    end

    always_comb begin
        mem_d = mem_q;
        if (erase_i) begin
            for (int i = 0; i < TOTAL; i++) begin
                if ((i / SECT_BYTES) == sect_sel) mem_d[i] = 8'hFF;
            end
        end
        if (prog_i) begin
            for (int k = 0; k < LANES; k++) begin
                mem_d[lane_idx[k]] = mem_q[lane_idx[k]] & wdata_i[8*k +: 8];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < TOTAL; i++) mem_q[i] <= 8'hFF;
        end else begin
            mem_q <= mem_d;
        end
    end

endmodule

// File: rtl/nfl_qrom.sv
module nfl_qrom
    import nfl_pkg::*;
#(
    parameter int DATA_W     = 16,
    parameter int SECT_BYTES = 16,
    parameter int SECT_CNT   = 4,
    parameter int ADDR_W     = 8
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic [7:0]        byte_o
);

    localparam int         LANE_SH   = $clog2(DATA_W / 8);
    localparam int         TOTAL     = SECT_BYTES * SECT_CNT;
    localparam logic [7:0] SIZE_LOG  = 8'($clog2(TOTAL));
    localparam logic [7:0] BUF_CODE  = (DATA_W == 8) ? 8'd8 : 8'd11;
    localparam logic [7:0] REG_LO    = 8'((SECT_CNT - 1) & 255);
    localparam logic [7:0] REG_HI    = 8'(((SECT_CNT - 1) >> 8) & 255);
    localparam logic [7:0] SECT_MID  = 8'((SECT_BYTES >> 8) & 255);
    localparam logic [7:0] SECT_HIGH = 8'((SECT_BYTES >> 16) & 255);

    logic [7:0] idx;

    function automatic logic [7:0] entry(input logic [7:0] ix);
        case (ix)
            8'h10: return 8'h51;
            8'h11: return 8'h52;
            8'h12: return 8'h59;
            8'h13: return 8'h01;
            8'h15: return 8'h31;
            8'h1B: return 8'h45;
            8'h1C: return 8'h55;
            8'h1F: return 8'h07;
            8'h20: return 8'h07;
            8'h21: return 8'h0A;
            8'h23: return 8'h04;
            8'h24: return 8'h04;
            8'h25: return 8'h04;
            8'h27: return SIZE_LOG;
            8'h28: return 8'h02;
            8'h2A: return BUF_CODE;
            8'h2C: return 8'h01;
            8'h2D: return REG_LO;
            8'h2E: return REG_HI;
            8'h2F: return SECT_MID;
            8'h30: return SECT_HIGH;
            8'h31: return 8'h50;
            8'h32: return 8'h52;
            8'h33: return 8'h49;
            8'h34: return 8'h31;
            8'h35: return 8'h31;
            default: return 8'h00;
        endcase
    endfunction

    assign idx    = addr_i[7:0] >> LANE_SH;
    assign byte_o = (int'(idx) >= QRY_LEN) ? 8'h00 : entry(idx);

endmodule

// File: rtl/nor_cmd_flash.sv
module nor_cmd_flash
    import nfl_pkg::*;
#(
    parameter  int DATA_W     = 16,
    parameter  int SECT_BYTES = 16,
    parameter  int SECT_CNT   = 4,
    localparam int ARR_BITS   = $clog2(SECT_BYTES * SECT_CNT),
    localparam int ADDR_W     = (ARR_BITS > 8) ? ARR_BITS : 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    input  logic              bus_re,
    output logic [DATA_W-1:0] bus_rdata
);

    logic [7:0]        ctl_cmd;
    phase_t            ctl_ph;
    logic [7:0]        ctl_stat;
    logic [7:0]        ctl_cnt;
    logic              do_prog;
    logic              do_erase;
    logic [DATA_W-1:0] cell_word;
    logic [7:0]        qry_byte;
    logic [DATA_W-1:0] rd_sel;
    logic [DATA_W-1:0] rd_d, rd_q;

    nfl_ctl u_ctl (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (bus_we),
        .code_i  (bus_wdata[7:0]),
        .cmd_o   (ctl_cmd),
        .ph_o    (ctl_ph),
        .stat_o  (ctl_stat),
        .cnt_o   (ctl_cnt),
        .prog_o  (do_prog),
        .erase_o (do_erase)
    );

    nfl_cells #(
        .DATA_W     (DATA_W),
        .SECT_BYTES (SECT_BYTES),
        .SECT_CNT   (SECT_CNT),
        .ADDR_W     (ADDR_W)
    ) u_cells (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr_i  (bus_addr),
        .wdata_i (bus_wdata),
        .prog_i  (do_prog),
        .erase_i (do_erase),
        .rword_o (cell_word)
    );

    nfl_qrom #(
        .DATA_W     (DATA_W),
        .SECT_BYTES (SECT_BYTES),
        .SECT_CNT   (SECT_CNT),
        .ADDR_W     (ADDR_W)
    ) u_qrom (
        .addr_i (bus_addr),
        .byte_o (qry_byte)
    );

    always_comb begin
        case (ctl_cmd)
            OP_ERASE, OP_CLR, OP_LOCK, OP_STAT, OP_BUF: rd_sel = DATA_W'(ctl_stat);
            OP_QUERY:                                   rd_sel = DATA_W'(qry_byte);
            default:                                    rd_sel = cell_word;
        endcase
        rd_d = bus_re ? rd_sel : rd_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign bus_rdata = rd_q;

endmodule

// File: rtl/nfl_chk.sv
module nfl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       we,
    input logic [7:0] code,
    input logic [7:0] cmd,
    input logic [1:0] ph,
    input logic [7:0] stat,
    input logic [7:0] cnt
);

    // R1
    phase_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ph != 2'd0) |-> (cmd != 8'h00));

    // R2
    prog_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && ph == 2'd1 && (cmd == 8'h10 || cmd == 8'h40))
        |=> (stat[7] && ph == 2'd0 && cmd == 8'h00));

    // R4
    stat_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && ph == 2'd0 && code == 8'h70) |=> (cmd == 8'h70 && ph == 2'd0));

    // R5
    stat_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && ph == 2'd0 && code == 8'h50) |=> (stat == 8'h00));

    // R6
    last_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && ph == 2'd2 && cnt == 8'h00) |=> (ph == 2'd3));

    // R6
    confirm_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ph == 2'd3) |-> (cmd == 8'hE8));

    // R10
    null_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && ph == 2'd0 && code == 8'h00) |=> (cmd == 8'h00 && ph == 2'd0));

endmodule

bind nor_cmd_flash nfl_chk u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (bus_we),
    .code  (bus_wdata[7:0]),
    .cmd   (ctl_cmd),
    .ph    (ctl_ph),
    .stat  (ctl_stat),
    .cnt   (ctl_cnt)
);

// File: tb/nor_cmd_flash_tb.sv
module nor_cmd_flash_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic        bus_re = 1'b0;
    logic [15:0] bus_rdata;
    logic        re_seen = 1'b0;

    int n_run = 0;
    int n_fail = 0;

    logic [15:0] exp_q[$];
    string       tag_q[$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    nor_cmd_flash #(.DATA_W(16), .SECT_BYTES(16), .SECT_CNT(4)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_we    (bus_we),
        .bus_re    (bus_re),
        .bus_rdata (bus_rdata)
    );

    task automatic check(input logic [15:0] got, input logic [15:0] exp, input string tag);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [15:0] exp, input string tag);
        @(negedge clk);
        bus_addr = a;
        bus_re   = 1'b1;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        bus_re   = 1'b0;
    endtask

    always @(posedge clk) re_seen <= bus_re && rst_n;

    always @(negedge clk) begin
        if (re_seen) begin
            if (exp_q.size() == 0) begin
                n_run++;
                n_fail++;
                $display("FAIL scoreboard: got %h expected nothing", bus_rdata);
            end else begin
                logic [15:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(bus_rdata, e, t);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check(bus_rdata, 16'h0000, "R12 reset rdata");

        // R1 erased array, zero status
        rd(8'h00, 16'hFFFF, "R1 array after reset");
        wr(8'h00, 16'h0070);
        rd(8'h00, 16'h0000, "R1 R4 status after reset");
        wr(8'h00, 16'h00FF);

        // R2 program and AND semantics, R11 byte order
        wr(8'h00, 16'h0040);
        wr(8'h04, 16'h12F0);
        rd(8'h04, 16'h12F0, "R2 program");
        wr(8'h00, 16'h0010);
        wr(8'h04, 16'hFF0F);
        rd(8'h04, 16'h1200, "R2 program clears bits only");
        wr(8'h00, 16'h0040);
        wr(8'h08, 16'hA55A);
        rd(8'h08, 16'hA55A, "R11 aligned word");
        rd(8'h09, 16'hFFA5, "R11 odd address little-endian");
        wr(8'h00, 16'h0070);
        rd(8'h00, 16'h0080, "R2 ready bit");

        // R5 clear status
        wr(8'h00, 16'h0050);
        rd(8'h00, 16'hFFFF, "R5 back to array");
        wr(8'h00, 16'h0070);
        rd(8'h00, 16'h0000, "R5 status cleared");
        wr(8'h00, 16'h00FF);

        // R3 erase with confirm
        wr(8'h06, 16'h0020);
        rd(8'h04, 16'h0080, "R3 R4 status during erase");
        wr(8'h00, 16'h00D0);
        rd(8'h00, 16'h0080, "R3 confirm keeps status");
        wr(8'h00, 16'h00FF);
        rd(8'h04, 16'hFFFF, "R3 sector erased");
        rd(8'h08, 16'hFFFF, "R3 sector erased upper");

        // R3 erase followed by a bad second value
        wr(8'h00, 16'h0040);
        wr(8'h10, 16'h0000);
        rd(8'h10, 16'h0000, "R2 program sector 1");
        wr(8'h10, 16'h0020);
        wr(8'h10, 16'h0055);
        rd(8'h10, 16'hFFFF, "R3 bad second value returns to array");

        // R6 buffered write
        wr(8'h00, 16'h0050);
        wr(8'h20, 16'h00E8);
        rd(8'h20, 16'h0080, "R6 buffer sets ready");
        wr(8'h20, 16'h0002);
        wr(8'h20, 16'h1111);
        wr(8'h22, 16'h2222);
        wr(8'h24, 16'h3333);
        wr(8'h20, 16'h00D0);
        rd(8'h20, 16'h0080, "R6 confirm keeps status");
        wr(8'h00, 16'h00FF);
        rd(8'h20, 16'h1111, "R6 word 0");
        rd(8'h22, 16'h2222, "R6 word 1");
        rd(8'h24, 16'h3333, "R6 word 2");
        rd(8'h26, 16'hFFFF, "R6 only N+1 words");
        wr(8'h28, 16'h00E8);
        wr(8'h28, 16'h0000);
        wr(8'h28, 16'h4444);
        wr(8'h28, 16'h0077);
        rd(8'h28, 16'h4444, "R6 bad confirm returns to array");

        // R7 lock sequences
        wr(8'h00, 16'h0050);
        wr(8'h00, 16'h0060);
        wr(8'h00, 16'h0001);
        rd(8'h00, 16'h0080, "R7 lock 0x01");
        wr(8'h00, 16'h0050);
        wr(8'h00, 16'h0060);
        wr(8'h00, 16'h00D0);
        rd(8'h00, 16'h0080, "R7 lock 0xD0");
        wr(8'h00, 16'h0050);
        wr(8'h00, 16'h0060);
        wr(8'h00, 16'h0033);
        rd(8'h20, 16'h1111, "R7 bad value returns to array");
        wr(8'h00, 16'h0070);
        rd(8'h00, 16'h0000, "R7 bad value leaves status");
        wr(8'h00, 16'h00FF);

        // R8 R9 query
        wr(8'h00, 16'h0098);
        rd(8'h20, 16'h0051, "R9 Q");
        rd(8'h22, 16'h0052, "R9 R");
        rd(8'h24, 16'h0059, "R9 Y");
        rd(8'h21, 16'h0051, "R8 index shift");
        rd(8'h54, 16'h000B, "R9 buffer size code");
        rd(8'hA4, 16'h0000, "R8 past table end");
        wr(8'h00, 16'h0012);
        rd(8'h20, 16'h0051, "R8 other write stays in query");
        wr(8'h00, 16'h00FF);
        rd(8'h20, 16'h1111, "R8 leave query");

        // R10 unknown and null codes
        wr(8'h00, 16'h0033);
        rd(8'h20, 16'h1111, "R10 unknown code");
        wr(8'h00, 16'h0070);
        wr(8'h00, 16'h0000);
        rd(8'h20, 16'h1111, "R10 null code");

        // R12 read data holds without strobe
        wr(8'h00, 16'h0070);
        repeat (3) @(negedge clk);
        check(bus_rdata, 16'h1111, "R12 rdata holds");

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            n_run++;
            n_fail++;
            $display("FAIL scoreboard: got %0d pending expected 0", exp_q.size());
        end
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule